// File: doc/BRIEF.md
# Tiered CPU reset sequencer

The block runs one of three nested reset levels for a processor core. A level is chosen from five trigger inputs: three operator keys, a load key and power-on. Each level runs a fixed chain of steps. A step issues a one-cycle strobe to the unit that does the work, then waits for that unit's done handshake before the next step starts.

The basic level flushes execution state and resets the I/O side. It leaves register and storage contents alone. The middle level runs the basic chain and then reinitializes the PSW, the timers and the control registers. The full level runs the middle chain and then clears the register files, starts page-storage initialization and discards saved machine data.

When the last step of the chosen level reports done, the block pulses a done flag and holds the core stopped until a start request arrives. A per-step watchdog abandons a chain whose handshake never returns.

Top module: `reset_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `stopped_o`, `timeout_o` and every `step_strobe_o` bit are low, and `level_o` is 0.
- R2: Level selection. `key_sys_norm_i` selects level 1 (program reset) and `key_load_norm_i` selects level 2 (initial program reset). `key_sys_clear_i`, `key_load_clear_i` and `power_on_i` each select level 3 (clear reset). When triggers arrive together, the highest level wins. `level_o` reports the level that was accepted.
- R3: A strobe lasts one cycle and at most one strobe bit is high at a time. Strobes occur only while `busy_o` is high. The next step's strobe never appears before `step_done_i` has reported done for the current step.
- R4: Step bit k of `step_strobe_o` and `step_done_i` maps as follows:
  - 0: abort the instruction and clear program and supervisor-call conditions
  - 1: clear external conditions
  - 2: clear machine-check, error and check-stop state
  - 3: flush the prefetch and store buffers
  - 4: channel system reset
  - 5: halt the save operation and invalidate partial save data
  - 6: zero the PSW, the CPU timer and the clock comparator
  - 7: initialize the control registers
  - 8: zero the general and floating-point registers
  - 9: page-storage initialization
  - 10: invalidate saved data

  Steps always run in ascending order starting at 0.
- R5: Level 1 runs steps 0 to 5 and never strobes steps 6 to 10, so register and storage contents are untouched.
- R6: Level 2 runs steps 0 to 7 and never strobes steps 8 to 10.
- R7: Level 3 runs steps 0 to 10.
- R8: While busy, the key triggers are ignored. `power_on_i` restarts the chain at step 0 with level 3.
- R9: When the last step's done is seen, `done_o` pulses for one cycle. In the same cycle `busy_o` falls and `stopped_o` rises. `stopped_o` stays high until `start_i` is asserted while idle, and an accepted trigger also clears it.
- R10: Step timeout. Suppose no done arrives in the first TIMEOUT_CYCLES cycles of a step's wait, where the wait starts the cycle after the strobe. Then `timeout_o` becomes visible TIMEOUT_CYCLES+1 cycles after the strobe cycle, the chain is abandoned, `done_o` stays low and `stopped_o` stays low. The next accepted trigger clears `timeout_o`.
- R11: Done bits of steps other than the step being waited on are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_sys_norm_i | input | 1 | Program-reset key |
| key_load_norm_i | input | 1 | Normal load key |
| key_sys_clear_i | input | 1 | Clear-reset key |
| key_load_clear_i | input | 1 | Clear load key |
| power_on_i | input | 1 | Power-on event |
| start_i | input | 1 | Start request that leaves the stopped state |
| step_done_i | input | 11 | Per-step done handshakes |
| step_strobe_o | output | 11 | Per-step one-cycle strobes |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | One-cycle completion pulse |
| stopped_o | output | 1 | Core held stopped |
| timeout_o | output | 1 | Step handshake timed out |
| level_o | output | 2 | Accepted level (1, 2 or 3) |

## Verification
Several properties are checked on every cycle:
- strobes are single-cycle, one-hot and occur only while busy;
- a level-1 or level-2 chain never strobes the steps beyond its tier;
- power-on always forces a level-3 restart;
- the done pulse is single-cycle and coincides with the stopped state;
- a timeout leaves the block idle.

Other behaviour only the bench scenarios can show:
- the full ascending step order for each trigger;
- that each strobe waits for its own handshake while other done bits are asserted as noise;
- the restart trace after a power-on mid-chain;
- the exact cycle of the timeout;
- keys that are dropped while busy.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_PROG  = 2'd1,
    LVL_INIT  = 2'd2,
    LVL_CLEAR = 2'd3
  } rst_level_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_WAIT   = 2'd2
  } seq_state_e;

  localparam int unsigned PROG_STEPS  = 6;
  localparam int unsigned INIT_STEPS  = 2;
  localparam int unsigned CLEAR_STEPS = 3;
  localparam int unsigned NUM_STEPS   = PROG_STEPS + INIT_STEPS + CLEAR_STEPS;
  localparam int unsigned STEP_W      = $clog2(NUM_STEPS);

  // final step index of each tier; tiers nest so each extends the previous
  function automatic logic [STEP_W-1:0] last_step(rst_level_e lvl);
    case (lvl)
      LVL_PROG:  return STEP_W'(PROG_STEPS - 1);
      LVL_INIT:  return STEP_W'(PROG_STEPS + INIT_STEPS - 1);
      LVL_CLEAR: return STEP_W'(NUM_STEPS - 1);
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/reset_trig_dec.sv
module reset_trig_dec
  import reset_seq_pkg::*;
(
  input  logic       key_sys_norm_i,
  input  logic       key_load_norm_i,
  input  logic       key_sys_clear_i,
  input  logic       key_load_clear_i,
  input  logic       power_on_i,
  input  logic       busy_i,
  output logic       go_o,
  output rst_level_e level_o
);

  always_comb begin
    go_o    = 1'b0;
    level_o = LVL_NONE;
    if (power_on_i) begin
      // power-on preempts a running chain
      go_o    = 1'b1;
      level_o = LVL_CLEAR;
    end else if (!busy_i) begin
      if (key_sys_clear_i || key_load_clear_i) begin
        go_o    = 1'b1;
        level_o = LVL_CLEAR;
      end else if (key_load_norm_i) begin
        go_o    = 1'b1;
        level_o = LVL_INIT;
      end else if (key_sys_norm_i) begin
        go_o    = 1'b1;
        level_o = LVL_PROG;
      end
    end
  end

endmodule

// File: rtl/reset_step_timer.sv
module reset_step_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (run_i && cnt_q != CW'(TIMEOUT_CYCLES - 1)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(TIMEOUT_CYCLES - 1));

endmodule

// File: rtl/reset_step_fsm.sv
module reset_step_fsm
  import reset_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  rst_level_e           go_level_i,
  input  logic                 start_i,
  input  logic [NUM_STEPS-1:0] step_done_i,
  input  logic                 expired_i,
  output logic [NUM_STEPS-1:0] step_strobe_o,
  output logic                 waiting_o,
  output logic                 strobing_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 stopped_o,
  output logic                 timeout_o,
  output logic [1:0]           level_o
);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  rst_level_e        level_q;
  logic              done_q, stopped_q, timeout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_IDLE;
      step_q    <= '0;
      level_q   <= LVL_NONE;
      done_q    <= 1'b0;
      stopped_q <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        state_q   <= SQ_STROBE;
        step_q    <= '0;
        level_q   <= go_level_i;
        stopped_q <= 1'b0;
        timeout_q <= 1'b0;
      end else begin
        unique case (state_q)
          SQ_STROBE: state_q <= SQ_WAIT;
          SQ_WAIT: begin
            if (step_done_i[step_q]) begin
              if (step_q == last_step(level_q)) begin
                state_q   <= SQ_IDLE;
                done_q    <= 1'b1;
                stopped_q <= 1'b1;
              end else begin
                step_q  <= step_q + 1'b1;
                state_q <= SQ_STROBE;
              end
            end else if (expired_i) begin
              state_q   <= SQ_IDLE;
              timeout_q <= 1'b1;
            end
          end
          default: if (start_i) stopped_q <= 1'b0;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_stb
    assign step_strobe_o[k] = (state_q == SQ_STROBE) && (step_q == STEP_W'(k));
  end

  assign waiting_o  = (state_q == SQ_WAIT);
  assign strobing_o = (state_q == SQ_STROBE);
  assign busy_o     = (state_q != SQ_IDLE);
  assign done_o     = done_q;
  assign stopped_o  = stopped_q;
  assign timeout_o  = timeout_q;
  assign level_o    = level_q;

endmodule

// File: rtl/reset_seq.sv
module reset_seq
  import reset_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_sys_norm_i,
  input  logic                 key_load_norm_i,
  input  logic                 key_sys_clear_i,
  input  logic                 key_load_clear_i,
  input  logic                 power_on_i,
  input  logic                 start_i,
  input  logic [NUM_STEPS-1:0] step_done_i,
  output logic [NUM_STEPS-1:0] step_strobe_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 stopped_o,
  output logic                 timeout_o,
  output logic [1:0]           level_o
);

  logic       go, waiting, strobing, expired;
  rst_level_e go_level;

  reset_trig_dec i_dec (
    .key_sys_norm_i   (key_sys_norm_i),
    .key_load_norm_i  (key_load_norm_i),
    .key_sys_clear_i  (key_sys_clear_i),
    .key_load_clear_i (key_load_clear_i),
    .power_on_i       (power_on_i),
    .busy_i           (busy_o),
    .go_o             (go),
    .level_o          (go_level)
  );

  reset_step_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (strobing),
    .run_i     (waiting),
    .expired_o (expired)
  );

  reset_step_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_i          (go),
    .go_level_i    (go_level),
    .start_i       (start_i),
    .step_done_i   (step_done_i),
    .expired_i     (expired),
    .step_strobe_o (step_strobe_o),
    .waiting_o     (waiting),
    .strobing_o    (strobing),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .stopped_o     (stopped_o),
    .timeout_o     (timeout_o),
    .level_o       (level_o)
  );

endmodule

// File: rtl/reset_seq_chk.sv
module reset_seq_chk
  import reset_seq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 power_on_i,
  input logic                 start_i,
  input logic [NUM_STEPS-1:0] step_strobe_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 stopped_o,
  input logic                 timeout_o,
  input logic [1:0]           level_o
);

  assert_strobe_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_strobe_o));

  assert_strobe_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_strobe_o) |=> (step_strobe_o == '0));

  assert_strobe_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_strobe_o) |-> busy_o);

  assert_prog_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && level_o == 2'd1) |-> (step_strobe_o[NUM_STEPS-1:PROG_STEPS] == '0));

  assert_init_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && level_o == 2'd2) |->
      (step_strobe_o[NUM_STEPS-1:PROG_STEPS+INIT_STEPS] == '0));

  assert_power_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_on_i |=> (busy_o && level_o == 2'd3 && step_strobe_o[0]));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stopped_o && !busy_o && !timeout_o));

  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && !busy_o && !start_i && !power_on_i) |=> (stopped_o || busy_o));

  assert_timeout_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!busy_o && !done_o && !stopped_o));

endmodule

bind reset_seq reset_seq_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .power_on_i    (power_on_i),
  .start_i       (start_i),
  .step_strobe_o (step_strobe_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .stopped_o     (stopped_o),
  .timeout_o     (timeout_o),
  .level_o       (level_o)
);

// File: tb/test_reset_seq.sv
module test_reset_seq;
  import reset_seq_pkg::*;

  localparam int TMO = 40;
  localparam int N   = NUM_STEPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic k_sn = 0, k_ln = 0, k_sc = 0, k_lc = 0, pwr = 0, start = 0;
  logic [N-1:0] done_v = '0;
  logic [N-1:0] strobe;
  logic busy, fin, stopped, tmo;
  logic [1:0] level;

  reset_seq #(.TIMEOUT_CYCLES(TMO)) i_reset_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .key_sys_norm_i(k_sn), .key_load_norm_i(k_ln),
    .key_sys_clear_i(k_sc), .key_load_clear_i(k_lc),
    .power_on_i(pwr), .start_i(start),
    .step_done_i(done_v), .step_strobe_o(strobe),
    .busy_o(busy), .done_o(fin), .stopped_o(stopped),
    .timeout_o(tmo), .level_o(level)
  );

  int total = 0, bad = 0;
  int slog [0:63];
  int log_n = 0, done_seen = 0, cur_step = 0, pend_idx = 0, pend_cnt = 0;
  int cyc = 0, last_stb_cyc = 0, tmo_gap = -1;
  bit deliv = 0, noise_en = 0, tmo_seen = 0;
  logic [N-1:0] hold_mask = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // unit models and trace monitor
  always @(negedge clk) begin
    cyc++;
    done_v = '0;
    if (pend_cnt == 1) begin
      done_v[pend_idx] = 1'b1;
      deliv = 1;
      pend_cnt = 0;
    end else if (pend_cnt > 1) pend_cnt--;
    if (|strobe) begin
      int k = 0;
      for (int i = 0; i < N; i++) if (strobe[i]) k = i;
      // R3/R11: a later step only after this step's own done was given
      if (k != 0) chk(deliv, "R3 R11 strobe before own done", 0, 1);
      deliv = 0;
      if (log_n < 64) slog[log_n] = k;
      log_n++;
      cur_step = k;
      last_stb_cyc = cyc;
      if (!hold_mask[k]) begin
        pend_idx = k;
        pend_cnt = $urandom_range(1, 6);
      end else pend_cnt = 0;
    end
    if (noise_en) begin
      logic [N-1:0] nz;
      nz = N'($urandom);
      nz[cur_step] = 1'b0;
      done_v = done_v | nz;
    end
    if (fin) done_seen++;
    if (tmo && !tmo_seen) begin
      tmo_seen = 1;
      tmo_gap = cyc - last_stb_cyc;
    end
  end

  task automatic fire(input logic [4:0] tm);
    @(negedge clk);
    {pwr, k_lc, k_sc, k_ln, k_sn} = tm;
    @(negedge clk);
    {pwr, k_lc, k_sc, k_ln, k_sn} = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  function automatic int exp_level(input logic [4:0] tm);
    if (tm[4] | tm[3] | tm[2]) return 3;
    if (tm[1]) return 2;
    return 1;
  endfunction

  function automatic int exp_last(input int lv);
    return (lv == 1) ? 5 : (lv == 2) ? 7 : 10;
  endfunction

  task automatic check_seq(input int lv, input int base, input string tag);
    int miss = 0;
    int last = exp_last(lv);
    chk(log_n == base + last + 1, {tag, " step count"}, log_n, base + last + 1);
    for (int i = 0; i <= last; i++) if (slog[base + i] != i) miss++;
    chk(miss == 0, {tag, " R4 ascending order"}, miss, 0);
    chk(done_seen == 1, "R9 single done pulse", done_seen, 1);
    chk(stopped && !busy, "R9 stopped after completion", stopped, 1);
    chk(int'(level) == lv, "R2 level", level, lv);
    chk(!tmo, "R10 no timeout", tmo, 0);
  endtask

  task automatic run(input logic [4:0] tm, input string tag);
    log_n = 0; done_seen = 0;
    fire(tm);
    wait_idle();
    check_seq(exp_level(tm), 0, tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk(strobe == '0 && !busy && !fin && !stopped && !tmo && level == 2'd0,
        "R1 reset state", {strobe, busy, fin, stopped, tmo, level}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && strobe == '0, "R1 idle after release", busy, 0);

    run(5'b00001, "R5 sys-normal");
    run(5'b00010, "R6 load-normal");
    run(5'b00100, "R7 sys-clear");
    run(5'b01000, "R7 load-clear");
    run(5'b10000, "R7 power-on");
    run(5'b00011, "R2 priority");

    // R9 stopped holds until start
    repeat (5) @(negedge clk);
    chk(stopped, "R9 stopped held", stopped, 1);
    start = 1; @(negedge clk); start = 0;
    chk(!stopped, "R9 start releases", stopped, 0);

    // R8 keys ignored while busy
    log_n = 0; done_seen = 0;
    fire(5'b01000);
    repeat (6) @(negedge clk);
    fire(5'b00111);
    wait_idle();
    check_seq(3, 0, "R8 keys ignored");

    // R8 power-on restart mid-chain
    log_n = 0; done_seen = 0;
    fire(5'b00001);
    begin int n = 0; while (log_n < 4 && n < 500) begin @(negedge clk); n++; end end
    fire(5'b10000);
    wait_idle();
    begin
      int miss = 0;
      for (int i = 0; i < 4; i++) if (slog[i] != i) miss++;
      chk(miss == 0, "R8 prefix before restart", miss, 0);
    end
    check_seq(3, 4, "R8 restart");

    // R11 with noise on other done bits
    noise_en = 1;
    run(5'b00010, "R11 noise");
    run(5'b00100, "R11 noise");
    noise_en = 0;

    // R10 timeout on step 2
    hold_mask = '0; hold_mask[2] = 1'b1;
    log_n = 0; done_seen = 0; tmo_seen = 0;
    fire(5'b00001);
    begin int n = 0; while (!tmo && n < 500) begin @(negedge clk); n++; end end
    @(negedge clk);
    chk(tmo_gap == TMO + 1, "R10 timeout cycle", tmo_gap, TMO + 1);
    chk(tmo && !busy, "R10 abandoned", busy, 0);
    chk(done_seen == 0 && !stopped, "R10 no done, not stopped", done_seen, 0);
    chk(log_n == 3, "R10 no later strobe", log_n, 3);
    hold_mask = '0;
    run(5'b00001, "R10 cleared by trigger");

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [4:0] tm;
      tm = '0;
      tm[$urandom_range(0, 4)] = 1'b1;
      if ($urandom_range(0, 3) == 0) tm[$urandom_range(0, 4)] = 1'b1;
      noise_en = $urandom_range(0, 1);
      run(tm, "R4 random");
      if ($urandom_range(0, 1) == 1) begin
        start = 1; @(negedge clk); start = 0;
        chk(!stopped, "R9 random start", stopped, 0);
      end
    end
    noise_en = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule